// File: doc/BRIEF.md
# Single-Wire Game Controller Poller

This block polls a game controller over one shared open-drain data line that a pull-up holds high when nobody pulls it down. On a start strobe it sends a one-byte status request (0x01) and a stop bit. It then stops pulling the line and decodes the controller's 32-bit reply. The reply carries the button states and the signed joystick X and Y bytes. The block only ever asks the pad to pull low. Releasing the line is the only way it produces a high level.

Every bit lasts 4 µs and is coded by pulse width. A zero is 3 µs low then 1 µs high. A one is 1 µs low then 3 µs high. Time is derived from the `CLK_HZ` parameter, and one microsecond equals `CLK_HZ/1_000_000` clocks. The asynchronous pad input passes through two flip-flops before any logic uses it. If the controller goes silent while a reply bit is expected, the poll is abandoned and an error flag is raised.

Top module: `joy_poller`

## Requirements
- R1: After reset `pad_oe`, `done` and `timeout_err` are 0, and `buttons`, `joy_x` and `joy_y` are 0.
- R2: A `poll_start` pulse in idle sends the command 0x01 MSB first, each bit spanning 4 µs (200 clocks at 50 MHz), with `pad_oe` high for 3 µs on a 0 and for 1 µs on a 1, and low for the rest of the bit.
- R3: The eighth command bit is followed by a stop bit, which is `pad_oe` high for 1 µs. The line is then released and `pad_oe` stays 0 until the next accepted poll.
- R4: While receiving, each reply bit starts at a falling edge of the synchronized pad. Its value is the pad level 2 µs after that edge, high giving 1. 32 data bits are taken MSB first, followed by one stop bit whose value is discarded.
- R5: After the reply's stop bit, `done` is high for exactly one clock. `buttons` holds the first 16 received bits, with the first bit received at bit 15 (A, then B, Z, Start toward bit 12). `joy_x` holds bits 17 to 24 and `joy_y` holds bits 25 to 32, each with its first bit at bit 7.
- R6: If no falling edge arrives within 100 µs (5000 clocks at 50 MHz) while a reply bit is awaited, `timeout_err` rises. The line stays released, `done` is not pulsed, the result outputs keep their previous values, and the poller returns to idle.
- R7: `timeout_err` stays high until the next accepted `poll_start`, which clears it.
- R8: `poll_start` is ignored while a poll is in progress. The running poll completes with correct data and no further command is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_start | input | 1 | One-clock request to start a poll |
| pad_in | input | 1 | Asynchronous level read from the data pad |
| pad_oe | output | 1 | Pull the data pad to ground when 1; release when 0 |
| buttons | output | 16 | Button bits from the first two reply bytes |
| joy_x | output | 8 | Signed joystick X byte |
| joy_y | output | 8 | Signed joystick Y byte |
| done | output | 1 | One-clock pulse when a reply has been captured |
| timeout_err | output | 1 | Set when the controller stops answering; cleared by the next poll |

## Verification
The assertions assume that the controller model pulls the line low only while the host has released it. They also assume that the model's low pulses are no shorter than the two-stage synchronizer latency, so each reply bit yields exactly one falling edge. The bench's controller model waits for the host's stop pulse to end before answering. Every reply bit it sends is either 1 µs or 3 µs low inside a 4 µs slot, and when it goes silent it simply leaves the line high. This keeps the stimulus inside those assumptions. It still covers a silent controller, a reply cut short mid-byte, and a start request that arrives in the middle of a reply.

// File: rtl/joy_poller.sv
module joy_poller #(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          TIMEOUT_US = 100,
  parameter logic [7:0]  CMD        = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_start,
  input  logic        pad_in,
  output logic        pad_oe,
  output logic [15:0] buttons,
  output logic [7:0]  joy_x,
  output logic [7:0]  joy_y,
  output logic        done,
  output logic        timeout_err
);

  localparam int US  = CLK_HZ / 1_000_000;
  localparam int BIT = 4 * US;
  localparam int TO  = TIMEOUT_US * US;
  localparam int CW  = $clog2(TO + BIT + 1);
  localparam logic [CW-1:0] T1   = CW'(US);
  localparam logic [CW-1:0] T3   = CW'(3 * US);
  localparam logic [CW-1:0] T1M  = CW'(US - 1);
  localparam logic [CW-1:0] T2M  = CW'(2 * US - 1);
  localparam logic [CW-1:0] TBM  = CW'(BIT - 1);
  localparam logic [CW-1:0] TTM  = CW'(TO - 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RXW, S_RXB} st_t;

  st_t            st;
  logic [1:0]     sync;
  logic           pad_q;
  logic [CW-1:0]  tcnt;
  logic [5:0]     bitcnt;
  logic [31:0]    shreg;

  wire fall    = pad_q & ~sync[1];
  wire stop    = (bitcnt == 6'd8);
  wire tx_bit  = stop ? 1'b1 : CMD[3'd7 - bitcnt[2:0]];
  wire [CW-1:0] low_len = tx_bit ? T1 : T3;

  assign pad_oe = (st == S_TX) && (tcnt < low_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync  <= 2'b11;
      pad_q <= 1'b1;
    end else begin
      sync  <= {sync[0], pad_in};
      pad_q <= sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tcnt        <= '0;
      bitcnt      <= '0;
      shreg       <= '0;
      buttons     <= '0;
      joy_x       <= '0;
      joy_y       <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (poll_start) begin
          st          <= S_TX;
          tcnt        <= '0;
          bitcnt      <= '0;
          timeout_err <= 1'b0;
        end
        S_TX: begin
          if (stop && tcnt == T1M) begin
            st     <= S_RXW;
            tcnt   <= '0;
            bitcnt <= '0;
          end else if (tcnt == TBM) begin
            tcnt   <= '0;
            bitcnt <= bitcnt + 6'd1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_RXW: begin
          if (fall) begin
            st   <= S_RXB;
            tcnt <= '0;
          end else if (tcnt == TTM) begin
            st          <= S_IDLE;
            timeout_err <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_RXB: begin
          if (tcnt == T2M) begin
            tcnt <= '0;
            if (bitcnt == 6'd32) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              buttons <= shreg[31:16];
              joy_x   <= shreg[15:8];
              joy_y   <= shreg[7:0];
            end else begin
              shreg  <= {shreg[30:0], sync[1]};
              bitcnt <= bitcnt + 6'd1;
              st     <= S_RXW;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] oe_run;
  always_ff @(posedge clk) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= pad_oe ? oe_run + 1'b1 : '0;
  end

  a_r2_low_max: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (oe_run < T3));
  a_r3_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RXW || st == S_RXB) |-> !pad_oe);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !timeout_err);
  a_r6_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!pad_oe && !done));
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !poll_start) |=> timeout_err);
  a_r8_idle_only_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && poll_start) |=> !$rose(pad_oe) || st == S_TX);

endmodule

// File: tb/sim_joy_poller.sv
module sim_joy_poller;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_start = 1'b0;
  logic ctl_low = 1'b0;
  logic pad_oe, done, timeout_err;
  logic [15:0] buttons;
  logic [7:0] joy_x, joy_y;
  wire pad_in = ~(pad_oe | ctl_low);

  int checks = 0, fails = 0;
  int cyc = 0, run = 0, npulse = 0, done_cnt = 0;
  int widths [0:15];
  int starts [0:15];

  always #10 clk = ~clk;

  joy_poller u0 (.clk(clk), .rst_n(rst_n), .poll_start(poll_start), .pad_in(pad_in),
    .pad_oe(pad_oe), .buttons(buttons), .joy_x(joy_x), .joy_y(joy_y),
    .done(done), .timeout_err(timeout_err));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (pad_oe) begin
      if (run == 0 && npulse < 16) starts[npulse] <= cyc;
      run <= run + 1;
    end else if (run != 0) begin
      if (npulse < 16) widths[npulse] <= run;
      npulse <= npulse + 1;
      run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    npulse = 0; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) poll_start = 1'b1;
    @(negedge clk) poll_start = 1'b0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 3000 && npulse < 9; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic send_bits(input logic [32:0] bits, input int n, input int start_at);
    for (int i = 0; i < n; i++) begin
      int lo;
      if (i == start_at) poll_start = 1'b1;
      lo = bits[32 - i] ? 50 : 150;
      ctl_low = 1'b1;
      repeat (lo) @(negedge clk);
      poll_start = 1'b0;
      ctl_low = 1'b0;
      repeat (200 - lo) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(pad_oe == 0, "R1 pad_oe", pad_oe, 0);
    chk(done == 0 && timeout_err == 0, "R1 flags", {done, timeout_err}, 0);
    chk({buttons, joy_x, joy_y} == 0, "R1 results", {buttons, joy_x, joy_y}, 0);
  endtask

  task automatic t_poll(input logic [31:0] data, input bit check_cmd, input int start_at);
    clear_mon();
    pulse_start();
    chk(timeout_err == 0, "R7 cleared by poll", timeout_err, 0);
    wait_stop();
    chk(npulse == 9, "R2 pulse count", npulse, 9);
    if (check_cmd) begin
      for (int i = 0; i < 8; i++)
        chk(widths[i] == ((i == 7) ? 50 : 150), "R2 cmd bit width", widths[i], (i == 7) ? 50 : 150);
      for (int i = 1; i < 9; i++)
        chk(starts[i] - starts[i-1] == 200, "R2 bit period", starts[i] - starts[i-1], 200);
      chk(widths[8] == 50, "R3 stop width", widths[8], 50);
    end
    repeat (100) @(negedge clk);
    send_bits({data, 1'b1}, 33, start_at);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R5 done once", done_cnt, 1);
    chk(buttons == data[31:16], "R5 buttons", buttons, data[31:16]);
    chk(joy_x == data[15:8], "R5 joy_x", joy_x, data[15:8]);
    chk(joy_y == data[7:0], "R5 joy_y", joy_y, data[7:0]);
    chk(timeout_err == 0, "R4 no error", timeout_err, 0);
    repeat (300) @(negedge clk);
    chk(npulse == 9, "R8 no extra command", npulse, 9);
  endtask

  task automatic t_silent(input int nbits, input logic [32:0] bits);
    logic [31:0] prev;
    int n;
    prev = {buttons, joy_x, joy_y};
    clear_mon();
    pulse_start();
    wait_stop();
    chk(npulse == 9, "R3 command sent", npulse, 9);
    n = 0;
    if (nbits > 0) begin
      repeat (60) @(negedge clk);
      send_bits(bits, nbits, -1);
      n = 150;
    end
    for (int i = 0; i < 7000 && !timeout_err; i++) begin
      @(negedge clk); n++;
    end
    chk(timeout_err == 1, "R6 timeout flag", timeout_err, 1);
    if (nbits == 0) chk(n >= 4995 && n <= 5010, "R6 timeout delay", n, 5000);
    chk(pad_oe == 0, "R6 released", pad_oe, 0);
    chk(done_cnt == 0, "R6 no done", done_cnt, 0);
    chk({buttons, joy_x, joy_y} == prev, "R6 results kept", {buttons, joy_x, joy_y}, prev);
    repeat (500) @(negedge clk);
    chk(timeout_err == 1, "R7 flag held", timeout_err, 1);
    chk(npulse == 9, "R3 line stays released", npulse, 9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R4 act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_poll(32'h8000_0000, 1'b1, -1);
    t_poll(32'h5A3C_7F80, 1'b0, -1);
    t_silent(0, '0);
    t_poll(32'h0123_FE01, 1'b0, 5);
    t_silent(10, 33'h1_5555_5555);
    t_poll(32'hF00F_C37E, 1'b0, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule